// File: doc/BRIEF.md
# Dual-Link CRC-32 Frame Transmitter

This block packs one fixed 256-bit frame from a set of measurement words and identification fields, and sends it as sixteen 16-bit words on consecutive clock cycles. The frame holds the card identifier, a running frame number, twelve measurement words and a CRC-32 remainder over the first fourteen words. The remainder is worked out while the data words go out, 16 bits per cycle, so the two CRC words follow the last measurement word with no gap.

Each word goes out on two independent output channels. Each channel has its own register set, and both carry the same data and control on every cycle, so a receiver can choose whichever link arrives intact. A single-cycle or held start strobe launches a frame. Inputs are captured on the launch edge. Start requests that arrive while a frame is on the wire are dropped. If start is held high, frames follow each other with no idle cycle between them.

Top module: `frame_tx`

## Requirements
- R1: A frame is 16 words on 16 consecutive cycles. Word 0 is visible in the cycle after the clock edge that samples an accepted start. Control bit 1 (valid) is high on exactly those 16 cycles and is low whenever no frame is being sent.
- R2: Control bit 0 (first) is high only with word 0. Control bits 3 and 2 are always zero.
- R3: Word 0 is the card identifier. Words 2 to 13 are the measurement slices taken from the most significant 16-bit slice of the measurement bus downward, so word 2 is bits 191:176.
- R4: Word 1 is the frame number, zero-extended to 16 bits. It is zero for the first frame after reset and rises by one with every frame. It wraps from its all-ones value (0xFFFF at the default FID_W of 16) to zero.
- R5: Words 14 and 15 are the upper and lower halves of a CRC-32 over words 0 to 13. The CRC uses polynomial 0x04C11DB7 and starts from 0xFFFFFFFF. Each word is fed in most significant bit first, and the final remainder is bitwise inverted.
- R6: Link A and link B carry identical data and control in every cycle.
- R7: Card identifier and measurement inputs are sampled only at the launch edge. Changing them while a frame is in flight does not alter that frame.
- R8: A start request sampled while a frame is in flight is ignored. This includes the edge that outputs word 15. A start sampled on the next edge launches a new frame directly after word 15.
- R9: Synchronous active-high reset drives all outputs to zero, aborts a frame in flight and returns the frame number to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Request to launch a frame |
| card_id | input | 16 | Card identifier placed in word 0 |
| meas_words | input | N_MEAS*16 (192) | Measurement words, most significant slice sent first |
| link_a_data | output | 16 | Frame word, link A |
| link_a_ctl | output | 4 | Control (bit 0 first, bit 1 valid), link A |
| link_b_data | output | 16 | Frame word, link B |
| link_b_ctl | output | 4 | Control (bit 0 first, bit 1 valid), link B |

## Verification
Two events can land on one edge: the last word of a frame and a new start request. Holding start high through a frame, or pulsing it in the cycle that emits word 15, puts frame completion and launch arbitration on the same or adjacent edges. The bench then checks three things: the pulse at word 15 produces no extra frame, a held start yields a new word 0 directly after word 15, and the new frame carries the next frame number and a fresh CRC. A second collision is reset arriving in the middle of a frame. The outputs must clear on that edge, and the following frame must restart numbering at zero.

// File: rtl/frame_tx_pkg.sv
`timescale 1ns/1ps
package frame_tx_pkg;

    localparam int WORD_W    = 16;
    localparam int CTL_W     = 4;
    localparam int CRC_W     = 32;
    localparam int NUM_LINKS = 2;
    localparam int CTL_FIRST = 0;
    localparam int CTL_VALID = 1;

    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [WORD_W-1:0] data;
    } link_word_t;

    // advance the remainder by one word, msb first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                  input logic [WORD_W-1:0] w);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            fb = c[CRC_W-1] ^ w[b];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/frame_crc.sv
`timescale 1ns/1ps
module frame_crc
    import frame_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_i,
    input  logic              adv_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst)         crc_q <= CRC_INIT;
        else if (seed_i) crc_q <= crc_step(CRC_INIT, word_i);
        else if (adv_i)  crc_q <= crc_step(crc_q, word_i);
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/frame_seq.sv
`timescale 1ns/1ps
module frame_seq
    import frame_tx_pkg::*;
#(
    parameter int N_MEAS = 12,
    parameter int FID_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic [WORD_W-1:0]        card_i,
    input  logic [N_MEAS*WORD_W-1:0] meas_i,
    input  logic [CRC_W-1:0]         crc_i,
    output logic                     crc_seed_o,
    output logic                     crc_adv_o,
    output link_word_t               nxt_o
);
    localparam int DATA_WORDS  = N_MEAS + 2;
    localparam int FRAME_WORDS = DATA_WORDS + CRC_W / WORD_W;
    localparam int IDX_W       = $clog2(FRAME_WORDS);
    localparam logic [IDX_W-1:0] IDX_CRC_HI = IDX_W'(DATA_WORDS);
    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(FRAME_WORDS - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
    } seq_state_t;

    seq_state_t        st_q;
    logic [WORD_W-1:0] hold_q [DATA_WORDS];
    logic [FID_W-1:0]  fid_q;
    logic              launch;

    assign launch = !st_q.busy && start_i;

    always_comb begin
        nxt_o      = '0;
        crc_seed_o = launch;
        crc_adv_o  = st_q.busy && (st_q.idx < IDX_CRC_HI);
        if (launch) begin
            nxt_o.data           = card_i;
            nxt_o.ctl[CTL_VALID] = 1'b1;
            nxt_o.ctl[CTL_FIRST] = 1'b1;
        end else if (st_q.busy) begin
            nxt_o.ctl[CTL_VALID] = 1'b1;
            if (st_q.idx < IDX_CRC_HI)       nxt_o.data = hold_q[st_q.idx];
            else if (st_q.idx == IDX_CRC_HI) nxt_o.data = ~crc_i[CRC_W-1:WORD_W];
            else                             nxt_o.data = ~crc_i[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            fid_q <= '0;
            for (int i = 0; i < DATA_WORDS; i++) hold_q[i] <= '0;
        end else if (launch) begin
            st_q.busy <= 1'b1;
            st_q.idx  <= IDX_W'(1);
            fid_q     <= fid_q + 1'b1;
            hold_q[0] <= card_i;
            hold_q[1] <= WORD_W'(fid_q);
            for (int j = 0; j < N_MEAS; j++)
                hold_q[2+j] <= meas_i[(N_MEAS-1-j)*WORD_W +: WORD_W];
        end else if (st_q.busy) begin
            if (st_q.idx == IDX_LAST) st_q <= '0;
            else                      st_q.idx <= st_q.idx + 1'b1;
        end
    end
endmodule

// File: rtl/frame_link_out.sv
`timescale 1ns/1ps
module frame_link_out
    import frame_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  link_word_t        nxt_i,
    output logic [WORD_W-1:0] data_o,
    output logic [CTL_W-1:0]  ctl_o
);
    link_word_t out_q;

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= nxt_i;
    end

    assign data_o = out_q.data;
    assign ctl_o  = out_q.ctl;
endmodule

// File: rtl/frame_tx.sv
`timescale 1ns/1ps
module frame_tx
    import frame_tx_pkg::*;
#(
    parameter int N_MEAS = 12,
    parameter int FID_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_start,
    input  logic [WORD_W-1:0]        card_id,
    input  logic [N_MEAS*WORD_W-1:0] meas_words,
    output logic [WORD_W-1:0]        link_a_data,
    output logic [CTL_W-1:0]         link_a_ctl,
    output logic [WORD_W-1:0]        link_b_data,
    output logic [CTL_W-1:0]         link_b_ctl
);
    link_word_t        nxt;
    logic              crc_seed, crc_adv;
    logic [CRC_W-1:0]  crc;
    logic [WORD_W-1:0] data_l [NUM_LINKS];
    logic [CTL_W-1:0]  ctl_l  [NUM_LINKS];

    frame_seq #(.N_MEAS(N_MEAS), .FID_W(FID_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (frame_start),
        .card_i     (card_id),
        .meas_i     (meas_words),
        .crc_i      (crc),
        .crc_seed_o (crc_seed),
        .crc_adv_o  (crc_adv),
        .nxt_o      (nxt)
    );

    frame_crc u_crc (
        .clk    (clk),
        .rst    (rst),
        .seed_i (crc_seed),
        .adv_i  (crc_adv),
        .word_i (nxt.data),
        .crc_o  (crc)
    );

    // one private register set per redundant link
    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
        frame_link_out u_out (
            .clk    (clk),
            .rst    (rst),
            .nxt_i  (nxt),
            .data_o (data_l[g]),
            .ctl_o  (ctl_l[g])
        );
    end

    assign link_a_data = data_l[0];
    assign link_a_ctl  = ctl_l[0];
    assign link_b_data = data_l[1];
    assign link_b_ctl  = ctl_l[1];
endmodule

// File: rtl/frame_tx_check.sv
`timescale 1ns/1ps
module frame_tx_check
    import frame_tx_pkg::*;
#(
    parameter int N_MEAS = 12,
    parameter int FID_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] link_a_data,
    input logic [CTL_W-1:0]  link_a_ctl,
    input logic [WORD_W-1:0] link_b_data,
    input logic [CTL_W-1:0]  link_b_ctl
);
    localparam int FRAME_WORDS = N_MEAS + 2 + CRC_W / WORD_W;
    localparam int CW          = $clog2(FRAME_WORDS + 1);
    localparam logic [CW-1:0] RUN_FULL = CW'(FRAME_WORDS);
    localparam logic [CW-1:0] RUN_ONE  = CW'(1);

    logic [CW-1:0]    run_q;
    logic [FID_W-1:0] last_fid_q;
    logic             have_fid_q;
    logic             vld, fst;

    assign vld = link_a_ctl[CTL_VALID];
    assign fst = link_a_ctl[CTL_FIRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q      <= '0;
            last_fid_q <= '0;
            have_fid_q <= 1'b0;
        end else begin
            if (!vld)     run_q <= '0;
            else if (fst) run_q <= RUN_ONE;
            else          run_q <= run_q + 1'b1;
            if (vld && !fst && run_q == RUN_ONE) begin
                last_fid_q <= link_a_data[FID_W-1:0];
                have_fid_q <= 1'b1;
            end
        end
    end

    a_r6_links_match: assert property (@(posedge clk) disable iff (rst)
        (link_a_data == link_b_data) && (link_a_ctl == link_b_ctl));

    a_r2_upper_ctl_zero: assert property (@(posedge clk) disable iff (rst)
        link_a_ctl[CTL_W-1:2] == '0);

    a_r2_first_has_valid: assert property (@(posedge clk) disable iff (rst)
        fst |-> vld);

    a_r1_valid_run: assert property (@(posedge clk) disable iff (rst)
        (vld && !fst) |-> (run_q >= RUN_ONE && run_q < RUN_FULL));

    a_r1_first_spacing: assert property (@(posedge clk) disable iff (rst)
        fst |-> (run_q == '0 || run_q == RUN_FULL));

    a_r1_idle_after_run: assert property (@(posedge clk) disable iff (rst)
        !vld |-> (run_q == '0 || run_q == RUN_FULL));

    a_r4_first_fid_zero: assert property (@(posedge clk) disable iff (rst)
        (vld && !fst && run_q == RUN_ONE && !have_fid_q) |-> link_a_data == '0);

    a_r4_fid_step: assert property (@(posedge clk) disable iff (rst)
        (vld && !fst && run_q == RUN_ONE && have_fid_q)
            |-> link_a_data == WORD_W'(FID_W'(last_fid_q + 1'b1)));

    a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (link_a_ctl == '0 && link_a_data == '0));
endmodule

bind frame_tx frame_tx_check #(.N_MEAS(N_MEAS), .FID_W(FID_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .link_a_data (link_a_data),
    .link_a_ctl  (link_a_ctl),
    .link_b_data (link_b_data),
    .link_b_ctl  (link_b_ctl)
);

// File: tb/frame_tx_test.sv
`timescale 1ns/1ps
module frame_tx_test;
    localparam int NM = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   card = '0;
    logic [NM*16-1:0] meas = '0;
    logic [15:0]   ad, bd, wad, wbd;
    logic [3:0]    ac, bc, wac, wbc;

    int n_chk  = 0;
    int n_fail = 0;
    int fid_exp = 0;
    bit done = 1'b0;
    logic [15:0] exp_w [16];

    always #2.5 clk = ~clk;

    frame_tx uut (
        .clk(clk), .rst(rst), .frame_start(start), .card_id(card), .meas_words(meas),
        .link_a_data(ad), .link_a_ctl(ac), .link_b_data(bd), .link_b_ctl(bc));

    // narrow frame counter copy to reach the wrap point quickly
    frame_tx #(.FID_W(2)) uut_wrap (
        .clk(clk), .rst(rst), .frame_start(start), .card_id(card), .meas_words(meas),
        .link_a_data(wad), .link_a_ctl(wac), .link_b_data(wbd), .link_b_ctl(wbc));

    // stimulus table: {hold_start, scramble_after_launch, card, seed, step}
    localparam logic [49:0] VEC [6] = '{
        {1'b0, 1'b0, 16'hA5C3, 16'h0000, 16'h0001},
        {1'b0, 1'b1, 16'h0001, 16'hFFFF, 16'h0000},
        {1'b1, 1'b0, 16'h7E01, 16'h1234, 16'h1111},
        {1'b1, 1'b1, 16'hFFFF, 16'h8000, 16'h0101},
        {1'b0, 1'b0, 16'h3C3C, 16'hDEAD, 16'hBEEF},
        {1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000}
    };

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc();
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 14; k++)
            for (int b = 15; b >= 0; b--) begin
                fb = c[31] ^ exp_w[k][b];
                c  = {c[30:0], 1'b0};
                if (fb) c = c ^ 32'h04C1_1DB7;
            end
        return ~c;
    endfunction

    task automatic run_frame(input logic [15:0] cid, input logic [15:0] seed,
                             input logic [15:0] step, input bit hold, input bit scr);
        logic [31:0] crc;
        logic [3:0]  ectl;
        exp_w[0] = cid;
        exp_w[1] = 16'(fid_exp);
        for (int j = 0; j < NM; j++) begin
            exp_w[2+j] = 16'(seed + 16'(j) * step);
            meas[(NM-1-j)*16 +: 16] = exp_w[2+j];
        end
        crc = ref_crc();
        exp_w[14] = crc[31:16];
        exp_w[15] = crc[15:0];
        card  = cid;
        start = 1'b1;
        for (int k = 0; k < 16; k++) begin
            tick();
            ectl = (k == 0) ? 4'b0011 : 4'b0010;
            if (k == 0 || k >= 2 && k <= 13)
                chk(ad == exp_w[k], "R3 data word", {16'h0, ad}, {16'h0, exp_w[k]});
            else if (k == 1)
                chk(ad == exp_w[k], "R4 frame number", {16'h0, ad}, {16'h0, exp_w[k]});
            else
                chk(ad == exp_w[k], "R5 crc word", {16'h0, ad}, {16'h0, exp_w[k]});
            chk(ac == ectl, "R1 R2 control", {28'h0, ac}, {28'h0, ectl});
            chk(bd == ad && bc == ac, "R6 link b copy", {12'h0, bc, bd}, {12'h0, ac, ad});
            if (k == 1)
                chk(wad == 16'(fid_exp & 3), "R4 wrap copy", {16'h0, wad}, fid_exp & 3);
            if (!hold) begin
                // R8: pulses during the frame, incl. the edge of word 15
                start = (k == 6 || k == 14);
            end
            if (k == 0 && scr) begin
                // R7: inputs change right after launch
                card = ~card;
                meas = ~meas;
            end
        end
        fid_exp++;
        if (!hold) begin
            tick();
            chk(ac == 4'h0 && ad == 16'h0, "R1 R8 idle after frame", {12'h0, ac, ad}, 0);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        chk(ad == 0 && ac == 0 && bd == 0 && bc == 0, "R9 reset outputs",
            {ac, ad, bc, bd}, 0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(ac == 0 && bc == 0, "R1 no frame without start", {24'h0, ac, bc}, 0);
        end

        for (int v = 0; v < 6; v++)
            run_frame(VEC[v][47:32], VEC[v][31:16], VEC[v][15:0], VEC[v][49], VEC[v][48]);

        // R4: narrow counter has wrapped 3 -> 0 on the way; one more pass pins it
        run_frame(16'h5555, 16'h0101, 16'h0202, 1'b0, 1'b0);
        chk(fid_exp == 7, "R4 frames counted", fid_exp, 7);

        // R9: reset in the middle of a frame
        card = 16'h1357;
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(ac == 4'b0011, "R1 launch before abort", {28'h0, ac}, 32'h3);
        for (int i = 0; i < 4; i++) tick();
        rst = 1'b1;
        tick();
        chk(ac == 0 && ad == 0 && bc == 0 && bd == 0, "R9 abort clears", {ac, ad, bc, bd}, 0);
        rst = 1'b0;
        tick();
        chk(ac == 0 && bc == 0, "R9 stays idle", {24'h0, ac, bc}, 0);
        fid_exp = 0;
        run_frame(16'h2468, 16'h4000, 16'h0003, 1'b0, 1'b0);
        chk(fid_exp == 1, "R9 renumbered frame sent", fid_exp, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule